// File: doc/BRIEF.md
# Sized Arithmetic Stage with Condition Flags

This block is a one-stage arithmetic unit. Each accepted request carries an operation code, an operand size, a destination operand and a source operand. The block then produces a new destination value and updates a five-bit condition flag register. It supports addition, subtraction, comparison, arithmetic shift left by one, rotate left by one through the extend flag, and packed decimal addition with extend. Each operation works on the low byte, the low half-word or the full long word of the operands.

Only the bits of the active size take part in the result and in the flags. The destination bits above the active size pass through unchanged. The extend flag is held in the block between requests, so rotate and decimal add chain naturally across a sequence of operations. A divide-overflow indication can come in with any request and forces the overflow flag. Requests enter on a valid/ready stream and results leave on one. A result stays on the output, unchanged, until it is taken. A new request is accepted only when the output register is empty or is being emptied in the same cycle, so back-pressure on the output stalls the input with no bubble.

Top module: `sized_flag_alu`

## Requirements
- R1: While `rst` is high (synchronous, active high), the next clock edge clears `out_valid` and all five flags in `out_flags`. Flag bit positions: [4]=X (extend), [3]=N, [2]=Z, [1]=V, [0]=C.
- R2: `in_size` selects the active width: 0 = low 8 bits, 1 = low 16 bits, 2 or 3 = all 32 bits. The written result replaces only the active bits of `in_dst` and keeps every bit above them.
- R3: For every operation except decimal add, N equals the top active bit of the sized result, and Z is 1 exactly when all active bits of the sized result are 0.
- R4: Op 0 (add; codes 6 and 7 act the same) computes dst+src. C is the carry out of the active size, and X is set equal to C. V is 1 when both operands have the same sign and the result's sign differs from it.
- R5: Op 1 (subtract) computes dst-src. C is 1 on borrow (unsigned src > dst over the active size), and X is set equal to C. V is 1 when the operand signs differ and the result's sign differs from dst's sign.
- R6: Op 2 (compare) sets N, Z, V and C exactly as subtract does. It returns `in_dst` unchanged on `out_data` and leaves X unchanged.
- R7: Op 3 (shift left) shifts the active bits left by one and puts 0 into bit 0. X and C both take the old top active bit. V is 1 when the top active bit changes.
- R8: Op 4 (rotate through extend) shifts the active bits left by one and puts the old X into bit 0. X and C both take the old top active bit, and V is 0.
- R9: Op 5 (decimal add) adds dst, src and the old X as packed 4-bit decimal digits over the active size. X and C are set on a decimal carry out of the top active digit. Z is cleared if the result is nonzero and is otherwise kept. N and V keep their old values.
- R10: A request with `in_dvf` high sets V to 1, whatever the operation.
- R11: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. A request is taken when `in_valid` and `in_ready` are both high, and its result appears on the next edge. While `out_valid` is high and `out_ready` is low, `out_data` and `out_flags` hold. The flags change only when a request is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_op | input | 3 | Operation code |
| in_size | input | 2 | Operand size code |
| in_dst | input | 32 | Destination operand |
| in_src | input | 32 | Source operand |
| in_dvf | input | 1 | Divide-overflow indication, sets V |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 32 | New destination value |
| out_flags | output | 5 | Flag register {X,N,Z,V,C} |

## Verification
The flag register is the only state carried from one request to the next. A wrong X shows on `out_flags` in the same cycle as the result that set it. It also corrupts bit 0 of the next rotate and the low digit of the next decimal add, one accepted request later. A wrong output register or handshake state shows up at once: a changed value during a stall, a stuck `in_ready`, or a lost or duplicated result. The bench compares every cycle against a behavioural model, so it flags any of these on the first edge where they diverge.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_CMP  = 3'd2,
    OP_ASL  = 3'd3,
    OP_ROXL = 3'd4,
    OP_ABCD = 3'd5,
    OP_RS6  = 3'd6,
    OP_RS7  = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic x;
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] mask,
  input  logic [DW-1:0] sgn,
  input  logic          sub,
  output logic [DW-1:0] res,
  output logic          cy,
  output logic          ov
);
  logic [DW:0] am, bm, t;
  logic sa, sb, sr;

  always_comb begin
    am  = {1'b0, a & mask};
    bm  = {1'b0, b & mask};
    t   = sub ? (am - bm) : (am + bm);
    res = t[DW-1:0];
    sa  = |(a & sgn);
    sb  = |(b & sgn);
    sr  = |(res & sgn);
    if (sub) begin
      cy = (bm > am);
      ov = (sa != sb) && (sr != sa);
    end else begin
      cy = |(t & {sgn, 1'b0});
      ov = (sa == sb) && (sr != sa);
    end
  end
endmodule

// File: rtl/alu_shrot.sv
module alu_shrot #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] sgn,
  input  logic          xin,
  input  logic          rot,
  output logic [DW-1:0] res,
  output logic          outbit,
  output logic          ov
);
  logic next_top;

  always_comb begin
    res      = {a[DW-2:0], rot & xin};
    outbit   = |(a & sgn);
    next_top = |(a & (sgn >> 1));
    ov       = rot ? 1'b0 : (outbit != next_top);
  end
endmodule

// File: rtl/alu_bcd.sv
module alu_bcd #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          xin,
  input  logic [1:0]    size,
  output logic [DW-1:0] res,
  output logic          cout
);
  localparam int ND = DW / 4;
  localparam int BD = ND / 4;
  localparam int WD = ND / 2;

  logic [ND:0] cy;
  assign cy[0] = xin;

  for (genvar i = 0; i < ND; i++) begin : g_digit
    logic [4:0] raw, fix;
    logic       over;
    assign raw  = {1'b0, a[4*i +: 4]} + {1'b0, b[4*i +: 4]} + {4'b0, cy[i]};
    assign over = (raw > 5'd9);
    assign fix  = over ? (raw + 5'd6) : raw;
    assign res[4*i +: 4] = fix[3:0];
    assign cy[i+1] = over;
  end

  always_comb begin
    case (size)
      2'd0:    cout = cy[BD];
      2'd1:    cout = cy[WD];
      default: cout = cy[ND];
    endcase
  end
endmodule

// File: rtl/sized_flag_alu.sv
module sized_flag_alu
  import alu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    in_op,
  input  logic [1:0]    in_size,
  input  logic [DW-1:0] in_dst,
  input  logic [DW-1:0] in_src,
  input  logic          in_dvf,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic [4:0]    out_flags
);
  localparam int BW = DW / 4;
  localparam int WW = DW / 2;
  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  alu_op_e op;
  logic [DW-1:0] mask, sgn;
  ccr_t flags_q, flags_d;
  logic [DW-1:0] as_res, sr_res, bcd_res, sized, data_d;
  logic as_c, as_v, sr_out, sr_v, bcd_c, res_zero, res_neg, accept;

  assign op = alu_op_e'(in_op);

  always_comb begin
    case (in_size)
      2'd0: begin
        mask = (ONE << BW) - ONE;
        sgn  = ONE << (BW - 1);
      end
      2'd1: begin
        mask = (ONE << WW) - ONE;
        sgn  = ONE << (WW - 1);
      end
      default: begin
        mask = '1;
        sgn  = ONE << (DW - 1);
      end
    endcase
  end

  alu_addsub #(.DW(DW)) u_addsub (
    .a(in_dst), .b(in_src), .mask(mask), .sgn(sgn),
    .sub((op == OP_SUB) || (op == OP_CMP)),
    .res(as_res), .cy(as_c), .ov(as_v)
  );

  alu_shrot #(.DW(DW)) u_shrot (
    .a(in_dst), .sgn(sgn), .xin(flags_q.x), .rot(op == OP_ROXL),
    .res(sr_res), .outbit(sr_out), .ov(sr_v)
  );

  alu_bcd #(.DW(DW)) u_bcd (
    .a(in_dst), .b(in_src), .xin(flags_q.x), .size(in_size),
    .res(bcd_res), .cout(bcd_c)
  );

  always_comb begin
    case (op)
      OP_ASL, OP_ROXL: sized = sr_res;
      OP_ABCD:         sized = bcd_res;
      default:         sized = as_res;
    endcase
  end

  assign res_zero = ((sized & mask) == '0);
  assign res_neg  = |(sized & sgn);

  always_comb begin
    flags_d = flags_q;
    case (op)
      OP_SUB, OP_CMP: begin
        flags_d.c = as_c;
        flags_d.v = as_v;
        if (op == OP_SUB) flags_d.x = as_c;
      end
      OP_ASL, OP_ROXL: begin
        flags_d.c = sr_out;
        flags_d.x = sr_out;
        flags_d.v = sr_v;
      end
      OP_ABCD: begin
        flags_d.c = bcd_c;
        flags_d.x = bcd_c;
      end
      default: begin
        flags_d.c = as_c;
        flags_d.x = as_c;
        flags_d.v = as_v;
      end
    endcase
    if (op == OP_ABCD) begin
      if (!res_zero) flags_d.z = 1'b0;
    end else begin
      flags_d.n = res_neg;
      flags_d.z = res_zero;
    end
    if (in_dvf) flags_d.v = 1'b1;
  end

  assign data_d   = (op == OP_CMP) ? in_dst : ((in_dst & ~mask) | (sized & mask));
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      flags_q   <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= data_d;
      flags_q   <= flags_d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign out_flags = flags_q;
endmodule

// File: rtl/sized_flag_alu_chk.sv
module sized_flag_alu_chk
  import alu_pkg::*;
#(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic [2:0]    in_op,
  input logic [1:0]    in_size,
  input logic [DW-1:0] in_dst,
  input logic          in_dvf,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic [4:0]    out_flags
);
  localparam int BW = DW / 4;
  logic take;
  assign take = in_valid && in_ready;

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!out_valid && out_flags == 5'd0)); // R1

  AST_BYTE_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
    (take && in_size == 2'd0 && in_op != OP_CMP) |=> out_data[DW-1:BW] == $past(in_dst[DW-1:BW])); // R2

  AST_CMP_DST_SAME: assert property (@(posedge clk) disable iff (rst)
    (take && in_op == OP_CMP) |=> out_data == $past(in_dst)); // R6

  AST_CMP_X_KEPT: assert property (@(posedge clk) disable iff (rst)
    (take && in_op == OP_CMP) |=> out_flags[4] == $past(out_flags[4])); // R6

  AST_ROT_BIT0: assert property (@(posedge clk) disable iff (rst)
    (take && in_op == OP_ROXL) |=> out_data[0] == $past(out_flags[4])); // R8

  AST_DIV_OVF_V: assert property (@(posedge clk) disable iff (rst)
    (take && in_dvf) |=> out_flags[1]); // R10

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_flags))); // R11

  AST_FLAGS_IDLE: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(out_flags)); // R11
endmodule

bind sized_flag_alu sized_flag_alu_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_size(in_size), .in_dst(in_dst), .in_dvf(in_dvf),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_flags(out_flags)
);

// File: tb/sized_flag_alu_bench.sv
`timescale 1ns/100ps
module sized_flag_alu_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = 3'd0;
  logic [1:0]  in_size = 2'd0;
  logic [31:0] in_dst = '0;
  logic [31:0] in_src = '0;
  logic        in_dvf = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic [4:0]  out_flags;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  bit bp_on = 0;

  // behavioural reference state
  bit      mv;
  longint  md;
  bit      fx, fn, fz, fv, fc;
  string   mtag = "R1";

  always #2.5 clk = ~clk;

  sized_flag_alu u_sized_flag_alu (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_size(in_size), .in_dst(in_dst), .in_src(in_src),
    .in_dvf(in_dvf), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_flags(out_flags)
  );

  function automatic longint bcd_to_dec(longint v, int nd);
    longint d = 0;
    for (int i = nd - 1; i >= 0; i--) d = d * 10 + ((v >> (4 * i)) & 15);
    return d;
  endfunction

  function automatic longint dec_to_bcd(longint d, int nd);
    longint r = 0;
    for (int i = 0; i < nd; i++) begin
      r = r | ((d % 10) << (4 * i));
      d = d / 10;
    end
    return r;
  endfunction

  task automatic model_op(int op, int sz, longint dst, longint src, bit dvf);
    int w;
    longint mask, a, b, r, lim;
    bit sa, sb, sr;
    w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    mask = (64'd1 << w) - 1;
    a = dst & mask;
    b = src & mask;
    sa = a[w-1];
    sb = b[w-1];
    case (op)
      1, 2: begin
        r = (a - b) & mask;
        sr = r[w-1];
        fc = (a < b);
        fv = (sa != sb) && (sr != sa);
        if (op == 1) fx = fc;
        mtag = (op == 1) ? "R5" : "R6";
      end
      3: begin
        r = (a << 1) & mask;
        fc = sa;
        fx = sa;
        fv = sa ^ a[w-2];
        mtag = "R7";
      end
      4: begin
        r = ((a << 1) | longint'(fx)) & mask;
        fc = sa;
        fx = sa;
        fv = 0;
        mtag = "R8";
      end
      5: begin
        lim = 1;
        for (int i = 0; i < w / 4; i++) lim = lim * 10;
        r = bcd_to_dec(a, w / 4) + bcd_to_dec(b, w / 4) + longint'(fx);
        fc = (r >= lim);
        fx = fc;
        r = dec_to_bcd(r % lim, w / 4);
        if (r != 0) fz = 0;
        mtag = "R9";
      end
      default: begin
        r = a + b;
        fc = r[w];
        r = r & mask;
        sr = r[w-1];
        fv = (sa == sb) && (sr != sa);
        fx = fc;
        mtag = "R4";
      end
    endcase
    if (op != 5) begin
      fn = r[w-1];
      fz = (r == 0);
    end
    if (dvf) begin
      fv = 1;
      mtag = {mtag, "/R10"};
    end
    md = (op == 2) ? (dst & 64'hFFFF_FFFF) : (((dst & ~mask) | r) & 64'hFFFF_FFFF);
  endtask

  always @(posedge clk) begin
    if (rst) begin
      mv = 0; md = 0;
      {fx, fn, fz, fv, fc} = 5'b0;
    end else if (in_valid && (!mv || out_ready)) begin
      model_op(int'(in_op), int'(in_size), longint'(in_dst), longint'(in_src), in_dvf);
      mv = 1;
    end else if (out_ready) begin
      mv = 0;
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      if (rst) begin
        compared++;
        if (out_valid !== 1'b0 || out_flags !== 5'd0) begin
          mismatched++;
          $display("FAIL R1 reset: valid=%b flags=%b expected valid=0 flags=00000", out_valid, out_flags);
        end
      end else begin
        compared++;
        if (in_ready !== (!mv || out_ready) || out_valid !== mv) begin
          mismatched++;
          $display("FAIL R11 handshake: ready=%b valid=%b expected ready=%b valid=%b",
                   in_ready, out_valid, (!mv || out_ready), mv);
        end
        if (mv) begin
          compared++;
          if (out_data !== md[31:0]) begin
            mismatched++;
            $display("FAIL %s/R2 data: got %h expected %h", mtag, out_data, md[31:0]);
          end
          compared++;
          if (out_flags !== {fx, fn, fz, fv, fc}) begin
            mismatched++;
            $display("FAIL %s/R3 flags XNZVC: got %b expected %b", mtag, out_flags, {fx, fn, fz, fv, fc});
          end
        end
      end
    end
  end

  task automatic send(int op, int sz, logic [31:0] d, logic [31:0] s, bit dvf);
    in_valid = 1;
    in_op = 3'(op);
    in_size = 2'(sz);
    in_dst = d;
    in_src = s;
    in_dvf = dvf;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk);
    #1 in_valid = 0;
  endtask

  function automatic logic [31:0] rand_bcd();
    logic [31:0] v = '0;
    for (int i = 0; i < 8; i++) v[4*i +: 4] = 4'($urandom % 10);
    return v;
  endfunction

  task automatic finish_run();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1 if (bp_on) out_ready = (($urandom % 10) < 6);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not end, got hang expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R4: byte carry, upper bits of dst preserved (R2)
    send(0, 0, 32'hAAAA_BBFF, 32'h0000_00FF, 0);
    // R4: signed overflow on positive + positive, and negative + negative
    send(0, 0, 32'h0000_0041, 32'h0000_0046, 0);
    send(0, 0, 32'h1234_56DE, 32'h0000_009F, 0);
    // R5: byte borrow and overflow cases
    send(1, 0, 32'hFFFF_FF12, 32'h0000_0034, 0);
    send(1, 0, 32'h0000_0041, 32'h0000_0087, 0);
    send(1, 0, 32'h0000_0095, 32'h0000_007F, 0);
    // R3: zero over active word only
    send(1, 1, 32'hFFFF_1234, 32'h0000_1234, 0);
    // R6: compare leaves dst and X
    send(2, 2, 32'h0000_0001, 32'h0000_0002, 0);
    // R7: shift out of top byte bit
    send(3, 0, 32'h5555_5581, 32'h0, 0);
    // R8: rotate brings X in
    send(4, 1, 32'h0000_8000, 32'h0, 0);
    send(4, 1, 32'h0000_0001, 32'h0, 0);
    // R9: decimal add with carry and zero keep
    send(0, 0, 32'h0, 32'h0, 0);
    send(5, 0, 32'h0000_0099, 32'h0000_0000, 0);
    send(1, 0, 32'h0000_0000, 32'h0000_0001, 0);
    send(5, 0, 32'h0000_0099, 32'h0000_0000, 0);
    send(5, 2, 32'h9999_9999, 32'h0000_0001, 0);
    // R10: divide overflow sets V
    send(0, 2, 32'h1, 32'h1, 1);
    // size code 3 acts as long (R2)
    send(0, 3, 32'h7FFF_FFFF, 32'h1, 0);
    // R11: random traffic with output back-pressure
    bp_on = 1;
    for (int k = 0; k < 600; k++) begin
      int op = $urandom % 6;
      if (op == 5) send(op, $urandom % 4, rand_bcd(), rand_bcd(), ($urandom % 8) == 0);
      else send(op, $urandom % 4, $urandom, $urandom, ($urandom % 8) == 0);
    end
    bp_on = 0;
    @(posedge clk);
    #1 out_ready = 1;
    repeat (5) @(posedge clk);
    finish_run();
  end
endmodule